// File: doc/BRIEF.md
# Strobed-Enable Bytewide Memory Controller

This block sits on the host side of a bytewide nonvolatile memory that latches its address when chip enable falls. It accepts one read or write request at a time through a valid/ready handshake and turns it into a full bus cycle. A bus cycle has three parts: a short setup phase with chip enable high, an access phase with chip enable low, and a precharge phase with chip enable high again. Chip enable is never left low from one transfer to the next, so every transfer gets its own falling edge.

The setup, access and precharge lengths are whole clock cycles. They are derived from a clock period and nanosecond targets given as parameters. The access phase is also clamped to a maximum chip-enable low time. A read captures the memory data in the last access cycle and returns it with a one-cycle valid pulse. A write holds write enable low from before the chip-enable falling edge, so the memory treats the cycle as a write from its start and never drives the bus. Reads and writes take the same number of cycles. A new request may follow a write at once, and no status polling is needed.

Top module: `strobe_mem_ctrl`

## Requirements
- R1: Each accepted request produces exactly one chip-enable low pulse (`mem_ce_n` 0). Chip enable is high in the cycle after acceptance, so every access starts with a new falling edge.
- R2: The memory address, and for writes the write data, are loaded from the request at acceptance. They stay unchanged from the setup phase until chip enable rises. Changes on `req_addr`, `req_wdata` or `req_write` after acceptance have no effect on the cycle in progress.
- R3: Between two chip-enable low pulses, chip enable stays high for at least PRECHARGE cycles (default 12 at a 5 ns period, that is 60 ns rounded up).
- R4: Each chip-enable low pulse lasts exactly ACCESS cycles. ACCESS is the 70 ns target rounded up to whole cycles (default 14), and it is limited to MAX_LOW_CYC.
- R5: Reads and writes occupy the bus for the same time. From acceptance, SETUP_CYC cycles of setup (default 1), ACCESS cycles of access and PRECHARGE cycles of precharge pass, and then `req_ready` is high again.
- R6: In a write, `mem_we_n` is 0 and `mem_dq_oe` is 1 throughout the setup and access phases, so write enable is low before chip enable falls. `mem_oe_n` stays 1. Both return to their idle values in the cycle where chip enable rises.
- R7: In a read, `mem_oe_n` is 0 only during the access phase, and `mem_we_n` stays 1 and `mem_dq_oe` stays 0. `mem_rdata` is sampled on the last access cycle. `rsp_valid` is 1 for exactly one cycle, the first precharge cycle, with `rsp_rdata` holding that sample. `rsp_rdata` keeps its value until the next read completes.
- R8: While `rst_n` is 0, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe`, `rsp_valid` and `req_ready` are 0, and the address, write data and read data registers are 0. `req_ready` first rises after the third rising clock edge with `rst_n` high.
- R9: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until precharge is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse: read data available |
| rsp_rdata | output | 8 | Data of the last completed read |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 13 | Memory address |
| mem_wdata | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the data pad drivers |
| mem_rdata | input | 8 | Data from the memory |

## Verification
The hardest situation to reach from the ports is a request that disturbs a cycle already in progress. That covers request fields changing after acceptance and a reset that lands in the middle of an access phase. Chip enable must not reflect the new address, the interrupted read must not return data, and the next access must still get a full precharge. The stimulus scrambles the request fields on every idle-handshake cycle, holds `req_valid` high across back-to-back transfers, and asserts reset part-way through a read. A behavioural model with a byte store then predicts every port on every cycle.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2,
    PH_PRECH  = 2'd3
  } smc_phase_e;

  // Whole clock cycles covering a span, never less than one.
  function automatic int unsigned span_to_cycles(input int unsigned span_ps,
                                                 input int unsigned period_ps);
    int unsigned c;
    c = (span_ps + period_ps - 1) / period_ps;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/smc_rst_sync.sv
module smc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/smc_phase_timer.sv
module smc_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_en) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/smc_sequencer.sv
module smc_sequencer
  import smc_pkg::*;
#(
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned ACCESS_CYC = 14,
  parameter int unsigned PRECH_CYC  = 12,
  parameter int unsigned CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             wr_q,
  input  logic             tmr_expired,
  output smc_phase_e       phase,
  output logic             accept,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             capture,
  output logic             req_ready
);

  localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] ACCESS_LD = CNT_W'(ACCESS_CYC - 1);
  localparam logic [CNT_W-1:0] PRECH_LD  = CNT_W'(PRECH_CYC - 1);

  smc_phase_e phase_q;
  smc_phase_e phase_d;
  logic       live_q;

  assign req_ready = live_q && (phase_q == PH_IDLE);
  assign accept    = req_ready && req_valid;

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          phase_d  = PH_SETUP;
          tmr_load = 1'b1;
          tmr_val  = SETUP_LD;
        end
      end
      PH_SETUP: begin
        if (tmr_expired) begin
          phase_d  = PH_ACCESS;
          tmr_load = 1'b1;
          tmr_val  = ACCESS_LD;
        end
      end
      PH_ACCESS: begin
        if (tmr_expired) begin
          phase_d  = PH_PRECH;
          tmr_load = 1'b1;
          tmr_val  = PRECH_LD;
          capture  = !wr_q;
        end
      end
      PH_PRECH: begin
        if (tmr_expired) begin
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      live_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      live_q  <= 1'b1;
    end
  end

  assign phase = phase_q;

  // Ready drops right after a handshake.
  assert_ready_low_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // Ready only comes back at the end of precharge (after the first reset release).
  assert_ready_returns_from_precharge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_ready) && $past(live_q)) |-> ($past(phase_q) == PH_PRECH));

  // A capture is only raised for reads.
  assert_capture_only_reads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !wr_q);

endmodule

// File: rtl/smc_datapath.sv
module smc_datapath #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              wr_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [DATA_W-1:0] rdata_q;
  logic              rv_q;

  // Request fields: loaded once at acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // Read data: loaded on the last access cycle of a read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
    end else begin
      rv_q <= capture;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_rdata = rdata_q;

  // Latched fields only move on a handshake.
  assert_fields_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(accept) |-> ($stable(addr_q) && $stable(wdata_q) && $stable(wr_q)));

endmodule

// File: rtl/strobe_mem_ctrl.sv
module strobe_mem_ctrl
  import smc_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 5000,
  parameter int unsigned ACCESS_PS     = 70000,
  parameter int unsigned PRECHARGE_PS  = 60000,
  parameter int unsigned SETUP_CYC     = 1,
  parameter int unsigned MAX_LOW_CYC   = 2000,
  parameter int unsigned ADDR_W        = 13,
  parameter int unsigned DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int unsigned ACC_RAW   = span_to_cycles(ACCESS_PS, CLK_PERIOD_PS);
  localparam int unsigned LOW_LIM   = (MAX_LOW_CYC == 0) ? 1 : MAX_LOW_CYC;
  localparam int unsigned ACC_CYC   = (ACC_RAW > LOW_LIM) ? LOW_LIM : ACC_RAW;
  localparam int unsigned PRE_CYC   = span_to_cycles(PRECHARGE_PS, CLK_PERIOD_PS);
  localparam int unsigned SET_CYC   = (SETUP_CYC == 0) ? 1 : SETUP_CYC;
  localparam int unsigned MAX_PH    = (ACC_CYC > PRE_CYC) ?
                                      ((ACC_CYC > SET_CYC) ? ACC_CYC : SET_CYC) :
                                      ((PRE_CYC > SET_CYC) ? PRE_CYC : SET_CYC);
  localparam int unsigned CNT_W     = $clog2(MAX_PH + 1);
  localparam int unsigned HI_W      = $clog2(PRE_CYC + 2);
  localparam int unsigned LO_W      = $clog2(LOW_LIM + 2);

  logic             rst_int_n;
  smc_phase_e       phase;
  logic             accept;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             capture;
  logic             wr_q;
  logic             busy_drive;

  smc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  smc_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_en  (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  smc_sequencer #(
    .SETUP_CYC  (SET_CYC),
    .ACCESS_CYC (ACC_CYC),
    .PRECH_CYC  (PRE_CYC),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_valid   (req_valid),
    .wr_q        (wr_q),
    .tmr_expired (tmr_expired),
    .phase       (phase),
    .accept      (accept),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .capture     (capture),
    .req_ready   (req_ready)
  );

  smc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .accept    (accept),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .capture   (capture),
    .mem_rdata (mem_rdata),
    .wr_q      (wr_q),
    .addr_q    (mem_addr),
    .wdata_q   (mem_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  // Pin decode from the registered phase.
  assign busy_drive = (phase == PH_SETUP) || (phase == PH_ACCESS);
  assign mem_ce_n   = (phase != PH_ACCESS);
  assign mem_we_n   = !(wr_q && busy_drive);
  assign mem_dq_oe  = wr_q && busy_drive;
  assign mem_oe_n   = !(!wr_q && (phase == PH_ACCESS));

  // ---- run-length counters on the enable pin, for the checks below ----
  logic [HI_W-1:0] hi_run_q;
  logic [LO_W-1:0] lo_run_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hi_run_q <= HI_W'(PRE_CYC);
      lo_run_q <= '0;
    end else begin
      if (mem_ce_n) begin
        if (hi_run_q < HI_W'(PRE_CYC)) hi_run_q <= hi_run_q + 1'b1;
        lo_run_q <= '0;
      end else begin
        hi_run_q <= '0;
        lo_run_q <= lo_run_q + 1'b1;
      end
    end
  end

  assert_enable_high_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    accept |=> mem_ce_n);

  assert_fall_from_setup_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(mem_ce_n) |-> ($past(phase) == PH_SETUP));

  assert_addr_stable_while_low_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !mem_ce_n |-> ($stable(mem_addr) && $stable(mem_wdata)));

  assert_precharge_min_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(mem_ce_n) |-> (hi_run_q >= HI_W'(PRE_CYC)));

  assert_low_within_access_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    !mem_ce_n |-> (lo_run_q < LO_W'(ACC_CYC)));

  assert_low_full_length_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(mem_ce_n) |-> (lo_run_q == LO_W'(ACC_CYC)));

  assert_write_pins_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe));

  assert_we_before_fall_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($fell(mem_ce_n) && mem_dq_oe) |-> $past(!mem_we_n));

  assert_rsp_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_valid |=> !rsp_valid);

  assert_rsp_at_precharge_start_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_valid |-> $rose(mem_ce_n));

  always @(posedge clk) begin
    if (!rst_int_n) begin
      assert_idle_pins_in_reset_R8: assert (mem_ce_n && mem_we_n && mem_oe_n &&
                                            !mem_dq_oe && !req_ready && !rsp_valid);
    end
  end

endmodule

// File: tb/strobe_mem_ctrl_tb_top.sv
module strobe_mem_ctrl_tb_top;

  localparam int PER_PS = 5000;
  localparam int S  = 1;
  localparam int A  = (70000 + PER_PS - 1) / PER_PS;
  localparam int P  = (60000 + PER_PS - 1) / PER_PS;
  localparam int DEPTH = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rsp_rdata, mem_wdata, mem_rdata;
  logic [12:0] mem_addr;

  always #2.5 clk = ~clk;

  strobe_mem_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_dq_oe(mem_dq_oe),
    .mem_rdata(mem_rdata)
  );

  // ---------------- memory device model ----------------
  logic [7:0]  fram [DEPTH];
  logic        dev_ce_q = 1'b1;
  logic [12:0] dev_lat = '0;
  logic [12:0] dev_rd_a;

  assign dev_rd_a  = dev_ce_q ? mem_addr : dev_lat;
  assign mem_rdata = (!mem_ce_n && !mem_oe_n) ? fram[dev_rd_a] : 8'h00;

  always @(posedge clk) begin
    if (dev_ce_q && !mem_ce_n) dev_lat <= mem_addr;
    if (!mem_ce_n && !mem_we_n) fram[dev_rd_a] <= mem_wdata;
    dev_ce_q <= mem_ce_n;
  end

  // ---------------- reference model ----------------
  logic [7:0]  shadow [DEPTH];
  bit          m_busy = 0, m_wr = 0, m_rv = 0;
  int          m_t = 0, m_sync = 0;
  logic [12:0] m_addr = '0;
  logic [7:0]  m_wdata = '0, m_rdata = '0;
  int          accepts = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_t = 0; m_sync = 0; m_rv = 0;
      m_wr = 0; m_addr = '0; m_wdata = '0; m_rdata = '0;
    end else begin
      bit can_acc;
      can_acc = (m_sync >= 3) && !m_busy;
      m_rv = 0;
      if (m_busy) begin
        if (m_t == S + A && !m_wr) begin
          m_rv = 1;
          m_rdata = shadow[m_addr];
        end
        if (m_t == S + A + P) m_busy = 0;
        else m_t++;
      end else if (can_acc && req_valid) begin
        m_busy = 1; m_t = 1;
        m_wr = req_write; m_addr = req_addr; m_wdata = req_wdata;
        if (req_write) shadow[req_addr] = req_wdata;
        accepts++;
      end
      if (m_sync < 3) m_sync++;
    end
  end

  // ---------------- checking ----------------
  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    bit st, ac;
    st = m_busy && (m_t <= S);
    ac = m_busy && (m_t > S) && (m_t <= S + A);
    chk("R1 R4 mem_ce_n", mem_ce_n, !ac);
    chk("R2 mem_addr", mem_addr, m_addr);
    chk("R2 mem_wdata", mem_wdata, m_wdata);
    chk("R6 mem_we_n", mem_we_n, !(m_wr && (st || ac)));
    chk("R6 mem_dq_oe", mem_dq_oe, m_wr && (st || ac));
    chk("R7 mem_oe_n", mem_oe_n, !(!m_wr && ac));
    chk("R5 R9 req_ready", req_ready, !m_busy && (m_sync >= 3));
    chk("R7 rsp_valid", rsp_valid, m_rv);
    chk("R7 rsp_rdata", rsp_rdata, m_rdata);
    if (!rst_n) chk("R8 reset pins idle", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 5'b11100);
  end

  // port statistics on the chip-enable pulses
  bit ce_prev = 1;
  int falls = 0, hi_len = 1000, lo_len = 0, min_hi = 1000;
  bit lo_wr = 0, in_low = 0;
  int rd_lo_min = 1000, rd_lo_max = 0, wr_lo_min = 1000, wr_lo_max = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      ce_prev = 1; in_low = 0; hi_len = 1000;
    end else begin
      if (ce_prev && !mem_ce_n) begin
        falls++;
        if (hi_len < min_hi) min_hi = hi_len;
        in_low = 1; lo_len = 1; lo_wr = !mem_we_n;
      end else if (!ce_prev && mem_ce_n) begin
        if (in_low) begin
          if (lo_wr) begin
            if (lo_len < wr_lo_min) wr_lo_min = lo_len;
            if (lo_len > wr_lo_max) wr_lo_max = lo_len;
          end else begin
            if (lo_len < rd_lo_min) rd_lo_min = lo_len;
            if (lo_len > rd_lo_max) rd_lo_max = lo_len;
          end
        end
        in_low = 0; hi_len = 1;
      end else if (mem_ce_n) begin
        if (hi_len < 1000) hi_len++;
      end else begin
        lo_len++;
      end
      ce_prev = mem_ce_n;
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R9 watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  task automatic scramble();
    req_addr  = 13'($urandom);
    req_wdata = 8'($urandom);
    req_write = 1'($urandom);
  endtask

  // called just after a falling edge
  task automatic send(input bit w, input logic [12:0] a, input logic [7:0] d, input bit keep_valid);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    if (!keep_valid) req_valid = 0;
    scramble();   // R2: later changes must not reach the memory pins
    if (keep_valid) begin req_valid = 1; end
  endtask

  task automatic idle(input int n);
    req_valid = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; scramble(); end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin fram[i] = 8'h00; shadow[i] = 8'h00; end
    // R8: reset state
    repeat (5) @(negedge clk);
    #1 rst_n = 1;
    idle(6);
    // R6 R7: address boundaries, back-to-back with valid held
    send(1, 13'h1FFF, 8'hA5, 1);
    send(1, 13'h0000, 8'h5A, 1);
    send(0, 13'h1FFF, 8'h00, 1);
    send(0, 13'h0000, 8'h00, 0);
    idle(40);
    // read immediately after write to the same location, across a row edge (R5)
    send(1, 13'h0007, 8'h3C, 0);
    send(0, 13'h0007, 8'h00, 0);
    send(1, 13'h0008, 8'hC3, 0);
    send(0, 13'h0008, 8'h00, 0);
    send(0, 13'h0123, 8'h00, 0);   // never written: expect 0
    idle(30);
    // random mix with idle gaps and scrambled fields (R2 R9)
    for (int k = 0; k < 160; k++) begin
      send(1'($urandom), 13'($urandom_range(0, 63)), 8'($urandom), 1'($urandom));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 20));
    end
    idle(40);
    // reset part-way through a read (R8), then normal service (R3)
    send(1, 13'h0AAA, 8'h77, 0);
    send(0, 13'h0AAA, 8'h00, 0);
    idle(5);
    rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(4);
    send(0, 13'h0AAA, 8'h00, 0);
    send(1, 13'h0AAA, 8'h11, 0);
    send(0, 13'h0AAA, 8'h00, 0);
    idle(40);
    // port-level summaries
    chk("R1 one low pulse per request", falls, accepts);
    chk("R3 minimum high gap", (min_hi >= P) ? 1 : 0, 1);
    chk("R4 read low length max", rd_lo_max, A);
    chk("R4 read low length min", rd_lo_min, A);
    chk("R5 write low length max", wr_lo_max, A);
    chk("R5 write low length min", wr_lo_min, A);
    chk("R6 stored byte", fram[13'h0AAA], 8'h11);
    chk("R6 stored byte boundary", fram[13'h1FFF], 8'hA5);
    finish_run();
  end

endmodule